// File: doc/BRIEF.md
# Lock-Step Pipeline Stall Controller

This block is the central controller for a linear pipeline of several stages. Each stage may need one or more cycles to finish its work on the item it holds, and it signals completion with a done pulse. The controller drives one enable shared by all stages. It moves the whole pipeline forward by one slot only when every occupied stage has finished and the consumer at the output can take the item in the last slot. The datapath logic inside the stages lies outside this block. The controller holds one data register and one occupancy bit per stage, so that items and bubbles move together.

Empty slots never hold the pipeline back, because a slot with no item counts as finished. When an advance loads an item into a slot, the controller clears that slot's finished flag. On the next cycle it gives the stage a one-cycle start pulse. The input side and the output side both use valid/ready handshakes. An input is taken exactly when the shared enable fires. The output is offered only when it will leave on the next advance.

Top module: `lockstep_stall_ctrl`

## Requirements
- R1: After reset every slot is empty. `out_valid` and every `stage_start` bit are 0, and `in_ready` and `stage_en` are 1.
- R2: `stage_en` is 1 in a cycle if and only if two conditions hold. First, every occupied slot has seen its `stage_done` bit high, either in an earlier cycle since it was loaded or in the current cycle. Second, the last slot is empty or `out_ready` is 1.
- R3: While any occupied slot has not yet reported done, `stage_en`, `in_ready` and `out_valid` stay 0, however long the stall lasts.
- R4: If `out_valid` is 1 while `out_ready` is 0, nothing advances. In the next cycle `out_valid` is still 1 and `out_data` is unchanged.
- R5: A `stage_done` bit has no effect in three cases: when its slot is empty, when it is raised before the slot's current item is loaded, and when it belongs to an operation that an advance has already closed. An item loaded later into that slot still stalls the pipeline until its own done.
- R6: An advance that loads an item into slot k makes `stage_start[k]` (bit k = stage k, bit 0 nearest the input) 1 for exactly the next cycle. An advance that loads a bubble into slot k gives no pulse.
- R7: An input is taken exactly in a cycle where `in_valid` and `in_ready` are both 1. `in_ready` equals `stage_en`. An advance with `in_valid` low loads a bubble into slot 0.
- R8: With every stage reporting done in its start cycle and `out_ready` held at 1, an item taken in cycle c appears with `out_valid` high in cycle c+N_STAGES.
- R9: Items leave in the order they were taken, with none lost and none repeated, under any pattern of stage latencies and `out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Producer offers an item |
| in_data | input | DATA_W | Item offered by the producer |
| in_ready | output | 1 | Item is taken this cycle if offered |
| stage_done | input | N_STAGES | Per-stage completion pulse or level |
| stage_en | output | 1 | Shared enable for all stage registers |
| stage_start | output | N_STAGES | Per-stage start pulse for a newly loaded item |
| out_valid | output | 1 | Last slot holds an item that leaves on the next advance |
| out_data | output | DATA_W | Item in the last slot |
| out_ready | input | 1 | Consumer can take the output |

## Verification
Taking a new item at the input and releasing the tail item at the output can happen in the same advance. The finishing done pulse of the slowest stage can also arrive in the same cycle that `out_ready` rises. The directed stall test keeps `out_ready` low while the last stage finishes, then raises it. The check is that the enable fires in that exact cycle and that the held item leaves only once. The random run mixes random stage latencies, random input gaps and random `out_ready` so that both kinds of coincidence happen many times. It judges them by checking that the output sequence numbers come out contiguous and that every held output stays stable.

// File: rtl/lsp_pkg.sv
package lsp_pkg;

  // A slot lets the pipeline move when it is empty, already finished,
  // or finishing in this very cycle.
  function automatic logic slot_clear(input logic occupied,
                                      input logic finished,
                                      input logic done_now);
    return !occupied || finished || done_now;
  endfunction

  // The tail may move when it is empty or the consumer takes it.
  function automatic logic tail_free(input logic tail_occupied,
                                     input logic sink_ready);
    return !tail_occupied || sink_ready;
  endfunction

endpackage

// File: rtl/lsp_slot.sv
module lsp_slot #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              up_v,
  input  logic [DATA_W-1:0] up_d,
  input  logic              done_in,
  output logic              v,
  output logic [DATA_W-1:0] d,
  output logic              clear,
  output logic              start
);
  import lsp_pkg::*;

  logic finished;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v        <= 1'b0;
      d        <= '0;
      finished <= 1'b0;
      start    <= 1'b0;
    end else begin
      start <= adv && up_v;
      if (adv) begin
        v        <= up_v;
        d        <= up_d;
        finished <= 1'b0;
      end else if (v && done_in) begin
        finished <= 1'b1;
      end
    end
  end

  assign clear = slot_clear(v, finished, done_in);

  // An occupied slot that has not finished must block the shared enable.
  assert_wait_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (v && !finished && !done_in) |-> !adv);

  // A loaded item gets its start pulse on the following cycle.
  assert_start_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && up_v) |=> (start && v));

  // A bubble never produces a start pulse.
  assert_no_start_bubble_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !up_v) |=> (!start && !v));

endmodule

// File: rtl/lsp_advance.sv
module lsp_advance #(
  parameter int N_STAGES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_STAGES-1:0] clear_vec,
  input  logic                tail_v,
  input  logic                sink_ready,
  output logic                all_clear,
  output logic                adv
);
  import lsp_pkg::*;

  assign all_clear = &clear_vec;
  assign adv       = all_clear && tail_free(tail_v, sink_ready);

  // An occupied tail never moves unless the consumer takes it.
  assert_tail_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_v && !sink_ready) |-> !adv);

  // With every slot clear and a free tail the enable must fire.
  assert_must_move_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (all_clear && (!tail_v || sink_ready)) |-> adv);

endmodule

// File: rtl/lockstep_stall_ctrl.sv
module lockstep_stall_ctrl #(
  parameter int N_STAGES = 4,
  parameter int DATA_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [DATA_W-1:0]   in_data,
  output logic                in_ready,
  input  logic [N_STAGES-1:0] stage_done,
  output logic                stage_en,
  output logic [N_STAGES-1:0] stage_start,
  output logic                out_valid,
  output logic [DATA_W-1:0]   out_data,
  input  logic                out_ready
);
  localparam int TAIL = N_STAGES - 1;

  logic [N_STAGES-1:0] slot_v;
  logic [N_STAGES-1:0] slot_clear;
  logic [DATA_W-1:0]   slot_d [N_STAGES];
  logic                all_clear;
  logic                adv;

  genvar k;
  generate
    for (k = 0; k < N_STAGES; k++) begin : g_slot
      logic              up_v;
      logic [DATA_W-1:0] up_d;
      if (k == 0) begin : g_head
        assign up_v = in_valid;
        assign up_d = in_data;
      end else begin : g_body
        assign up_v = slot_v[k-1];
        assign up_d = slot_d[k-1];
      end
      lsp_slot #(.DATA_W(DATA_W)) i_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv),
        .up_v    (up_v),
        .up_d    (up_d),
        .done_in (stage_done[k]),
        .v       (slot_v[k]),
        .d       (slot_d[k]),
        .clear   (slot_clear[k]),
        .start   (stage_start[k])
      );
    end
  endgenerate

  lsp_advance #(.N_STAGES(N_STAGES)) i_advance (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_vec  (slot_clear),
    .tail_v     (slot_v[TAIL]),
    .sink_ready (out_ready),
    .all_clear  (all_clear),
    .adv        (adv)
  );

  assign stage_en  = adv;
  assign in_ready  = adv;
  assign out_valid = slot_v[TAIL] && all_clear;
  assign out_data  = slot_d[TAIL];

  // A refused output is held, with its data, into the next cycle.
  assert_hold_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // An occupied tail leaves only through an accepted output handshake.
  assert_tail_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_en && slot_v[TAIL]) |-> (out_valid && out_ready));

  // While any slot is still busy, neither side may transfer.
  assert_quiet_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !all_clear |-> (!in_ready && !out_valid));

endmodule

// File: tb/test_lockstep_stall_ctrl.sv
`timescale 1ns/1ps
module test_lockstep_stall_ctrl;
  localparam int N = 4;
  localparam int W = 8;
  localparam int ITEMS = 200;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         in_ready;
  logic [N-1:0] stage_done;
  logic         stage_en;
  logic [N-1:0] stage_start;
  logic         out_valid;
  logic [W-1:0] out_data;
  logic         out_ready = 1'b0;

  logic         model_on = 1'b0;
  logic         rand_lat = 1'b0;
  logic [N-1:0] man_done = '0;
  logic [N-1:0] mdl_done = '0;
  int           cnt [N];

  int checks = 0;
  int fails = 0;
  int sent = 0;
  int recvd = 0;
  logic mon_on = 1'b0;
  logic prev_hold = 1'b0;
  logic [W-1:0] prev_data = '0;

  always #5 clk = ~clk;

  assign stage_done = model_on ? mdl_done : man_done;

  lockstep_stall_ctrl #(.N_STAGES(N), .DATA_W(W)) i_lockstep_stall_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .stage_done(stage_done), .stage_en(stage_en),
    .stage_start(stage_start), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready));

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Stage model: a start loads a latency, done pulses when it runs out.
  initial begin
    for (int k = 0; k < N; k++) cnt[k] = 0;
    forever begin
      @(posedge clk); #1;
      for (int k = 0; k < N; k++) begin
        mdl_done[k] = 1'b0;
        if (stage_start[k]) begin
          cnt[k] = rand_lat ? int'($urandom_range(3, 0)) : 0;
          if (cnt[k] == 0) mdl_done[k] = 1'b1;
        end else if (cnt[k] > 0) begin
          cnt[k]--;
          if (cnt[k] == 0) mdl_done[k] = 1'b1;
        end
      end
    end
  end

  // Output monitor for the random run: order (R9) and hold (R4).
  always @(negedge clk) begin
    if (mon_on) begin
      if (prev_hold)
        chk(out_valid && out_data == prev_data, "R4 hold", int'(out_data), int'(prev_data));
      if (out_valid && out_ready) begin
        chk(out_data == W'(recvd), "R9 order", int'(out_data), recvd & 8'hff);
        recvd++;
      end
      prev_hold = out_valid && !out_ready;
      prev_data = out_data;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!out_valid, "R1 out_valid", int'(out_valid), 0);
    chk(in_ready, "R1 in_ready", int'(in_ready), 1);
    chk(stage_en, "R1 stage_en", int'(stage_en), 1);
    chk(stage_start == '0, "R1 stage_start", int'(stage_start), 0);
  endtask

  task automatic t_latency();
    int lat;
    model_on = 1'b1; rand_lat = 1'b0; out_ready = 1'b1;
    step(); in_valid = 1'b1; in_data = 8'hA5;
    @(negedge clk);
    chk(in_ready, "R7 accept", int'(in_ready), 1);
    step(); in_valid = 1'b0;
    @(negedge clk);
    chk(stage_start[0], "R6 start0", int'(stage_start[0]), 1);
    chk(stage_start[N-1:1] == '0, "R6 no bubble start", int'(stage_start), 1);
    lat = 1;
    while (!out_valid && lat < 20) begin @(negedge clk); lat++; end
    chk(lat == N, "R8 latency", lat, N);
    chk(out_data == 8'hA5, "R8 data", int'(out_data), 8'hA5);
    @(negedge clk);
    chk(!out_valid, "R9 no duplicate", int'(out_valid), 0);
    model_on = 1'b0;
  endtask

  task automatic t_stall();
    out_ready = 1'b0; man_done = '0;
    step(); in_valid = 1'b1; in_data = 8'h11;
    @(negedge clk);
    chk(in_ready, "R7 take A", int'(in_ready), 1);
    step(); in_valid = 1'b1; in_data = 8'h22;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!stage_en && !in_ready, "R3 busy stall", int'(stage_en), 0);
      step();
    end
    man_done[0] = 1'b1;
    @(negedge clk);
    chk(stage_en && in_ready, "R2 done same cycle", int'(stage_en), 1);
    step(); man_done = '0; in_valid = 1'b0;
    @(negedge clk);
    chk(stage_start[1] && stage_start[0], "R6 start A and B", int'(stage_start), 3);
    chk(!stage_en, "R5 flag cleared", int'(stage_en), 0);
    step(); man_done[2] = 1'b1;
    @(negedge clk);
    chk(!stage_en, "R5 empty done", int'(stage_en), 0);
    step(); man_done = 4'b0011;
    @(negedge clk);
    chk(stage_en, "R2 both done", int'(stage_en), 1);
    step(); man_done = '0;
    @(negedge clk);
    chk(!stage_en, "R5 A in slot2 waits", int'(stage_en), 0);
    step(); man_done = 4'b0110;
    @(negedge clk);
    chk(stage_en, "R2 advance A", int'(stage_en), 1);
    step(); man_done = 4'b1000;
    @(negedge clk);
    chk(!stage_en, "R5 B waits in slot3? no, slot2", int'(stage_en), 0);
    step(); man_done = 4'b0100;
    @(negedge clk);
    chk(out_valid && !stage_en, "R4 refuse", int'(out_valid), 1);
    chk(out_data == 8'h11, "R4 data A", int'(out_data), 8'h11);
    step(); man_done = '0;
    @(negedge clk);
    chk(out_valid && out_data == 8'h11 && !stage_en, "R4 held", int'(out_data), 8'h11);
    step(); out_ready = 1'b1;
    @(negedge clk);
    chk(stage_en, "R2 ready releases", int'(stage_en), 1);
    step();
    @(negedge clk);
    chk(!out_valid, "R3 B not done", int'(out_valid), 0);
    step(); man_done = 4'b1000;
    @(negedge clk);
    chk(out_valid && out_data == 8'h22, "R9 B out", int'(out_data), 8'h22);
    step(); man_done = '0;
    @(negedge clk);
    chk(!out_valid && in_ready, "R9 empty again", int'(out_valid), 0);
  endtask

  task automatic t_random();
    int guard;
    model_on = 1'b1; rand_lat = 1'b1;
    sent = 0; recvd = 0; mon_on = 1'b1; prev_hold = 1'b0;
    guard = 0;
    while (recvd < ITEMS && guard < 20000) begin
      step();
      out_ready = ($urandom_range(9, 0) < 6);
      in_valid  = (sent < ITEMS) && ($urandom_range(9, 0) < 7);
      in_data   = W'(sent);
      @(negedge clk);
      if (in_valid && in_ready) sent++;
      guard++;
    end
    step(); in_valid = 1'b0;
    @(negedge clk);
    mon_on = 1'b0;
    chk(recvd == ITEMS, "R9 count out", recvd, ITEMS);
    chk(sent == ITEMS, "R7 count in", sent, ITEMS);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_latency();
    t_stall();
    t_random();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule